// File: doc/BRIEF.md
# 8b/10b Lane Receive Decoder

This block turns one word-aligned receive lane of 10-bit line code groups back into bytes. Each clock cycle with the input strobe high it takes one group. It checks the group against the running disparity it keeps and produces the 8-bit value, a control-character flag, a comma indication and an error flag. All outputs are registered one cycle after the input.

Any group that is not a legal code word, or that is legal only at the opposite running disparity, is reported in-band: the byte becomes 0xFF. A separate error flag marks it, so that a real data byte 0xFF can be told apart from an error. A decode-enable input switches the lane to raw pass-through. In that mode the 10-bit group is still presented and none of the decode flags are raised.

Top module: `rx_lane_decoder`

## Requirements
- R1: While `rst` is high and in the cycle after it, `out_vld` is low. The running disparity starts negative, so the negative-disparity form of a control character is accepted as the first group.
- R2: `out_vld` equals `in_vld` delayed by one clock. For every accepted group, `out_raw` carries that group one clock later, in both modes.
- R3: With `dec_en` high, each of the 256 data characters decodes to its byte `{HGF, EDCBA}`. This holds when the character is encoded as a standard encoder would send it at the current disparity, including the alternate x.7 forms, and `out_k` and `out_err` stay low. Bit order: `in_grp[9:4]` is abcdei and `in_grp[3:0]` is fghj, with `a` in bit 9.
- R4: The twelve control characters K28.0–K28.7, K23.7, K27.7, K29.7 and K30.7 decode to `{y, x}` (K28.5 gives 0xBC, K23.7 gives 0xF7) with `out_k` high. K28.5 is 0011111010 at negative and 1100000101 at positive disparity.
- R5: `out_comma` is high exactly for K28.1, K28.5 and K28.7 (0x3C, 0xBC, 0xFC with `out_k` high) and low for every other group.
- R6: A group that is no legal code word at either disparity gives `out_byte` = 0xFF, `out_err` high and `out_k` low.
- R7: A group that is legal only at the opposite running disparity gives `out_byte` = 0xFF and `out_err` high.
- R8: After each decoded group the running disparity becomes positive if the group has more than five ones and negative if it has fewer. It is unchanged if the group has exactly five ones. This rule also applies to groups flagged as errors.
- R9: The data character D31.7 yields byte 0xFF with `out_err` low.
- R10: With `dec_en` low, `out_byte` is 0x00 and `out_k`, `out_err` and `out_comma` are low. The running disparity is not changed by such groups.
- R11: A group whose first six bits are the K28 pattern but whose last four bits do not complete a listed control character is an error (0xFF, `out_err` high, `out_k` low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_en | input | 1 | 1 = decode, 0 = raw pass-through |
| in_vld | input | 1 | Input group strobe |
| in_grp | input | 10 | Code group, a in bit 9 through j in bit 0 |
| out_vld | output | 1 | Output strobe, one cycle after `in_vld` |
| out_byte | output | 8 | Decoded byte, 0xFF on error |
| out_k | output | 1 | Control character received |
| out_err | output | 1 | Code or disparity error |
| out_comma | output | 1 | Comma-bearing control character received |
| out_raw | output | 10 | Received group, registered |

## Verification
A wrong running-disparity bit is not visible on the group that corrupts it. It shows one group later, when a correctly encoded character is flagged as a disparity error with 0xFF. The bench therefore follows every error and every bypass group with a character encoded at the disparity the rules predict. A wrong table entry shows at once as a wrong byte for that one character. The full data sweep, run at continuously changing disparity, reaches every entry at both polarities.

// File: rtl/rxd_pkg.sv
`timescale 1ns/1ps
package rxd_pkg;
    localparam int GRP_W  = 10;
    localparam int BYTE_W = 8;
    localparam int SIX_W  = 6;
    localparam int FOUR_W = 4;
    localparam int LO_W   = 5;
    localparam int HI_W   = 3;
    localparam int LO_N   = 1 << LO_W;
    localparam int HI_N   = 1 << HI_W;

    typedef struct packed {
        logic            ok;
        logic            k28;
        logic [LO_W-1:0] x;
        logic            mid_pos;
    } six_res_t;

    typedef struct packed {
        logic            ok_d;
        logic [HI_W-1:0] yd;
        logic            ok_k;
        logic [HI_W-1:0] yk;
        logic            a7k;
    } four_res_t;

    typedef struct packed {
        logic              vld;
        logic [BYTE_W-1:0] dat;
        logic              k;
        logic              err;
        logic              comma;
        logic [GRP_W-1:0]  raw;
    } lane_out_t;

    // 6-bit sub-block at negative running disparity, abcdei with a as MSB
    function automatic logic [SIX_W-1:0] six_neg(input logic [LO_W-1:0] x);
        case (x)
            5'd0:  return 6'b100111;  5'd1:  return 6'b011101;
            5'd2:  return 6'b101101;  5'd3:  return 6'b110001;
            5'd4:  return 6'b110101;  5'd5:  return 6'b101001;
            5'd6:  return 6'b011001;  5'd7:  return 6'b111000;
            5'd8:  return 6'b111001;  5'd9:  return 6'b100101;
            5'd10: return 6'b010101;  5'd11: return 6'b110100;
            5'd12: return 6'b001101;  5'd13: return 6'b101100;
            5'd14: return 6'b011100;  5'd15: return 6'b010111;
            5'd16: return 6'b011011;  5'd17: return 6'b100011;
            5'd18: return 6'b010011;  5'd19: return 6'b110010;
            5'd20: return 6'b001011;  5'd21: return 6'b101010;
            5'd22: return 6'b011010;  5'd23: return 6'b111010;
            5'd24: return 6'b110011;  5'd25: return 6'b100110;
            5'd26: return 6'b010110;  5'd27: return 6'b110110;
            5'd28: return 6'b001110;  5'd29: return 6'b101110;
            5'd30: return 6'b011110;  default: return 6'b101011;
        endcase
    endfunction

    function automatic logic [SIX_W-1:0] enc6(input logic [LO_W-1:0] x, input logic pos);
        logic [SIX_W-1:0] c;
        c = six_neg(x);
        if (pos && (($countones(c) != 3) || (x == 5'd7))) c = ~c;
        return c;
    endfunction

    // 4-bit sub-block at negative disparity, fghj with f as MSB
    function automatic logic [FOUR_W-1:0] four_neg(input logic [HI_W-1:0] y, input logic alt);
        case (y)
            3'd0: return 4'b1011;  3'd1: return 4'b1001;
            3'd2: return 4'b0101;  3'd3: return 4'b1100;
            3'd4: return 4'b1101;  3'd5: return 4'b1010;
            3'd6: return 4'b0110;  default: return alt ? 4'b0111 : 4'b1110;
        endcase
    endfunction

    function automatic logic [FOUR_W-1:0] enc4(input logic [HI_W-1:0] y, input logic pos,
                                              input logic alt);
        logic [FOUR_W-1:0] c;
        c = four_neg(y, alt);
        if (pos && (y == 3'd0 || y == 3'd3 || y == 3'd4 || y == 3'd7)) c = ~c;
        return c;
    endfunction

    function automatic logic [FOUR_W-1:0] enc4_k28(input logic [HI_W-1:0] y, input logic pos);
        if (!pos && (y == 3'd1 || y == 3'd2 || y == 3'd5 || y == 3'd6))
            return ~four_neg(y, 1'b0);
        return enc4(y, pos, y == 3'd7);
    endfunction

    // the x values for which a data x.7 must use the alternate form
    function automatic logic need_alt(input logic [LO_W-1:0] x, input logic pos);
        if (pos) return (x == 5'd11) || (x == 5'd13) || (x == 5'd14);
        return (x == 5'd17) || (x == 5'd18) || (x == 5'd20);
    endfunction

    function automatic logic is_kx7(input logic [LO_W-1:0] x);
        return (x == 5'd23) || (x == 5'd27) || (x == 5'd29) || (x == 5'd30);
    endfunction
endpackage

// File: rtl/rxd_six_dec.sv
`timescale 1ns/1ps
module rxd_six_dec
    import rxd_pkg::*;
(
    input  logic [SIX_W-1:0] code,
    input  logic             rd_pos,
    output six_res_t         res
);
    logic [2:0] ones;

    always_comb begin
        res  = '0;
        ones = 3'($countones(code));
        for (int i = 0; i < LO_N; i++) begin
            if (enc6(LO_W'(i), rd_pos) == code) begin
                res.ok = 1'b1;
                res.x  = LO_W'(i);
            end
        end
        res.k28 = (code == (rd_pos ? 6'b110000 : 6'b001111));
        if (res.k28) res.x = 5'd28;
        if (ones > 3'd3)      res.mid_pos = 1'b1;
        else if (ones < 3'd3) res.mid_pos = 1'b0;
        else                  res.mid_pos = rd_pos;
    end
endmodule

// File: rtl/rxd_four_dec.sv
`timescale 1ns/1ps
module rxd_four_dec
    import rxd_pkg::*;
(
    input  logic [FOUR_W-1:0] code,
    input  logic              mid_pos,
    input  logic [LO_W-1:0]   x,
    output four_res_t         res
);
    always_comb begin
        res = '0;
        for (int j = 0; j < HI_N; j++) begin
            if (enc4(HI_W'(j), mid_pos, (j == HI_N - 1) && need_alt(x, mid_pos)) == code) begin
                res.ok_d = 1'b1;
                res.yd   = HI_W'(j);
            end
            if (enc4_k28(HI_W'(j), mid_pos) == code) begin
                res.ok_k = 1'b1;
                res.yk   = HI_W'(j);
            end
        end
        res.a7k = (code == (mid_pos ? 4'b1000 : 4'b0111));
    end
endmodule

// File: rtl/rx_lane_decoder.sv
`timescale 1ns/1ps
module rx_lane_decoder
    import rxd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              dec_en,
    input  logic              in_vld,
    input  logic [GRP_W-1:0]  in_grp,
    output logic              out_vld,
    output logic [BYTE_W-1:0] out_byte,
    output logic              out_k,
    output logic              out_err,
    output logic              out_comma,
    output logic [GRP_W-1:0]  out_raw
);
    logic      rd_pos_q;
    logic      rd_next;
    six_res_t  six_r;
    four_res_t four_r;
    lane_out_t nxt, cur_q;

    logic              dec_ok, dec_k, dec_comma;
    logic [BYTE_W-1:0] dec_dat;
    logic [3:0]        ones10;

    rxd_six_dec u_six (
        .code   (in_grp[GRP_W-1:FOUR_W]),
        .rd_pos (rd_pos_q),
        .res    (six_r)
    );

    rxd_four_dec u_four (
        .code    (in_grp[FOUR_W-1:0]),
        .mid_pos (six_r.mid_pos),
        .x       (six_r.x),
        .res     (four_r)
    );

    // classify the group
    always_comb begin
        dec_ok    = 1'b0;
        dec_k     = 1'b0;
        dec_dat   = '0;
        dec_comma = 1'b0;
        if (six_r.k28) begin
            dec_ok    = four_r.ok_k;
            dec_k     = 1'b1;
            dec_dat   = {four_r.yk, 5'd28};
            dec_comma = four_r.ok_k &&
                        (four_r.yk == 3'd1 || four_r.yk == 3'd5 || four_r.yk == 3'd7);
        end else if (six_r.ok && is_kx7(six_r.x) && four_r.a7k) begin
            dec_ok  = 1'b1;
            dec_k   = 1'b1;
            dec_dat = {3'b111, six_r.x};
        end else if (six_r.ok && four_r.ok_d) begin
            dec_ok  = 1'b1;
            dec_dat = {four_r.yd, six_r.x};
        end
    end

    // next running disparity from the whole group's balance
    always_comb begin
        ones10 = 4'($countones(in_grp));
        if (ones10 > 4'd5)      rd_next = 1'b1;
        else if (ones10 < 4'd5) rd_next = 1'b0;
        else                    rd_next = rd_pos_q;
    end

    always_comb begin
        nxt     = '0;
        nxt.vld = in_vld;
        nxt.raw = in_grp;
        if (dec_en) begin
            nxt.dat   = dec_ok ? dec_dat : 8'hFF;
            nxt.k     = dec_ok && dec_k;
            nxt.err   = !dec_ok;
            nxt.comma = dec_comma;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q    <= '0;
            rd_pos_q <= 1'b0;
        end else begin
            cur_q.vld <= in_vld;
            if (in_vld) cur_q <= nxt;
            if (in_vld && dec_en) rd_pos_q <= rd_next;
        end
    end

    assign out_vld   = cur_q.vld;
    assign out_byte  = cur_q.dat;
    assign out_k     = cur_q.k;
    assign out_err   = cur_q.err;
    assign out_comma = cur_q.comma;
    assign out_raw   = cur_q.raw;
endmodule

// File: rtl/rx_lane_decoder_chk.sv
`timescale 1ns/1ps
module rx_lane_decoder_chk
    import rxd_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              dec_en,
    input logic              in_vld,
    input logic [GRP_W-1:0]  in_grp,
    input logic              out_vld,
    input logic [BYTE_W-1:0] out_byte,
    input logic              out_k,
    input logic              out_err,
    input logic              out_comma,
    input logic [GRP_W-1:0]  out_raw
);
    // R2
    vld_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_vld |=> out_vld);
    // R2
    vld_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> !out_vld);
    // R2
    raw_pass_chk: assert property (@(posedge clk) disable iff (rst)
        in_vld |=> out_raw == $past(in_grp));
    // R6
    err_sub_chk: assert property (@(posedge clk) disable iff (rst)
        out_vld && out_err |-> out_byte == 8'hFF && !out_k && !out_comma);
    // R5
    comma_k_chk: assert property (@(posedge clk) disable iff (rst)
        out_vld && out_comma |-> out_k && (out_byte inside {8'h3C, 8'hBC, 8'hFC}));
    // R4
    k_value_chk: assert property (@(posedge clk) disable iff (rst)
        out_vld && out_k |-> (out_byte[4:0] == 5'd28) ||
                             (out_byte inside {8'hF7, 8'hFB, 8'hFD, 8'hFE}));
    // R10
    bypass_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        in_vld && !dec_en |=> !out_k && !out_err && !out_comma && out_byte == 8'h00);
endmodule

bind rx_lane_decoder rx_lane_decoder_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .dec_en    (dec_en),
    .in_vld    (in_vld),
    .in_grp    (in_grp),
    .out_vld   (out_vld),
    .out_byte  (out_byte),
    .out_k     (out_k),
    .out_err   (out_err),
    .out_comma (out_comma),
    .out_raw   (out_raw)
);

// File: tb/rx_lane_decoder_test.sv
`timescale 1ns/1ps
module rx_lane_decoder_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       dec_en = 1'b1;
    logic       in_vld = 1'b0;
    logic [9:0] in_grp = '0;
    logic       out_vld, out_k, out_err, out_comma;
    logic [7:0] out_byte;
    logic [9:0] out_raw;

    int checks = 0;
    int errors = 0;
    logic brd = 1'b0;
    logic done = 1'b0;

    typedef struct {
        logic       vld;
        logic [7:0] dat;
        logic       k;
        logic       err;
        logic       comma;
        logic [9:0] raw;
        string      req;
    } exp_t;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    rx_lane_decoder uut (
        .clk(clk), .rst(rst), .dec_en(dec_en), .in_vld(in_vld), .in_grp(in_grp),
        .out_vld(out_vld), .out_byte(out_byte), .out_k(out_k), .out_err(out_err),
        .out_comma(out_comma), .out_raw(out_raw)
    );

    function automatic logic [5:0] t6(input logic [4:0] x);
        logic [5:0] tab [32] = '{6'h27, 6'h1D, 6'h2D, 6'h31, 6'h35, 6'h29, 6'h19, 6'h38,
                                 6'h39, 6'h25, 6'h15, 6'h34, 6'h0D, 6'h2C, 6'h1C, 6'h17,
                                 6'h1B, 6'h23, 6'h13, 6'h32, 6'h0B, 6'h2A, 6'h1A, 6'h3A,
                                 6'h33, 6'h26, 6'h16, 6'h36, 6'h0E, 6'h2E, 6'h1E, 6'h2B};
        return tab[x];
    endfunction

    function automatic logic [3:0] t4(input logic [2:0] y);
        logic [3:0] tab [8] = '{4'hB, 4'h9, 4'h5, 4'hC, 4'hD, 4'hA, 4'h6, 4'hE};
        return tab[y];
    endfunction

    // control characters at negative disparity; positive form is the complement
    function automatic logic [9:0] kneg(input logic [7:0] b);
        case (b)
            8'h1C: return 10'b0011110100;  8'h3C: return 10'b0011111001;
            8'h5C: return 10'b0011110101;  8'h7C: return 10'b0011110011;
            8'h9C: return 10'b0011110010;  8'hBC: return 10'b0011111010;
            8'hDC: return 10'b0011110110;  8'hFC: return 10'b0011111000;
            8'hF7: return 10'b1110101000;  8'hFB: return 10'b1101101000;
            8'hFD: return 10'b1011101000;  default: return 10'b0111101000;
        endcase
    endfunction

    function automatic logic [9:0] benc(input logic [7:0] b, input logic k, input logic rd);
        logic [5:0] s;
        logic [3:0] f;
        logic       mid;
        logic [4:0] x;
        logic [2:0] y;
        if (k) return rd ? ~kneg(b) : kneg(b);
        x = b[4:0];
        y = b[7:5];
        s = t6(x);
        if (rd && ($countones(s) != 3 || x == 5'd7)) s = ~s;
        mid = ($countones(s) > 3) ? 1'b1 : ($countones(s) < 3) ? 1'b0 : rd;
        f = t4(y);
        if (y == 3'd7 && ((!mid && (x == 17 || x == 18 || x == 20)) ||
                          (mid && (x == 11 || x == 13 || x == 14)))) f = 4'b0111;
        if (mid && (y == 0 || y == 3 || y == 4 || y == 7)) f = ~f;
        return {s, f};
    endfunction

    task automatic drive(input logic v, input logic en, input logic [9:0] g,
                         input logic [7:0] edat, input logic ek, input logic eerr,
                         input string req);
        exp_t e;
        @(negedge clk);
        in_vld = v;
        dec_en = en;
        in_grp = g;
        e.vld = v; e.dat = edat; e.k = ek; e.err = eerr; e.raw = g; e.req = req;
        e.comma = ek && (edat == 8'h3C || edat == 8'hBC || edat == 8'hFC);
        sb.push_back(e);
        if (v && en) begin
            if ($countones(g) > 5) brd = 1'b1;
            else if ($countones(g) < 5) brd = 1'b0;
        end
    endtask

    task automatic send(input logic [7:0] b, input logic k, input string req);
        drive(1'b1, 1'b1, benc(b, k, brd), b, k, 1'b0, req);
    endtask

    // monitor: compare one expected item per cycle, shortly after the edge
    always @(posedge clk) begin
        exp_t e;
        #1;
        if (sb.size() > 0) begin
            e = sb.pop_front();
            checks++;
            if (out_vld !== e.vld ||
                (e.vld && (out_byte !== e.dat || out_k !== e.k || out_err !== e.err ||
                           out_comma !== e.comma || out_raw !== e.raw))) begin
                errors++;
                $display("FAIL %s: got vld=%b byte=%h k=%b err=%b comma=%b raw=%b exp vld=%b byte=%h k=%b err=%b comma=%b raw=%b",
                         e.req, out_vld, out_byte, out_k, out_err, out_comma, out_raw,
                         e.vld, e.dat, e.k, e.err, e.comma, e.raw);
            end
        end
    end

    task automatic report;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout exp completion");
        report();
    end

    initial begin
        logic [8:0] ks [12] = '{9'h1C, 9'h3C, 9'h5C, 9'h7C, 9'h9C, 9'hBC, 9'hDC, 9'hFC,
                               9'hF7, 9'hFB, 9'hFD, 9'hFE};
        // R1: reset holds the output strobe low
        for (int i = 0; i < 3; i++) begin
            @(posedge clk); #1;
            checks++;
            if (out_vld !== 1'b0) begin
                errors++;
                $display("FAIL R1: got out_vld=%b exp 0", out_vld);
            end
        end
        @(negedge clk);
        rst = 1'b0;
        brd = 1'b0;
        // R1 R4: negative-disparity K28.5 accepted first, then positive form
        drive(1'b1, 1'b1, 10'b0011111010, 8'hBC, 1'b1, 1'b0, "R1 R4 K28.5 neg");
        drive(1'b1, 1'b1, 10'b1100000101, 8'hBC, 1'b1, 1'b0, "R4 K28.5 pos");
        // R3: every data character, disparity running freely
        for (int b = 0; b < 256; b++) send(8'(b), 1'b0, "R3 data sweep");
        // R3: sweep again starting from the other polarity
        brd = ~brd;
        drive(1'b1, 1'b1, brd ? 10'b1111111111 : 10'b0000000000, 8'hFF, 1'b0, 1'b1, "R6 flip");
        for (int b = 0; b < 256; b++) send(8'(b), 1'b0, "R3 data sweep 2");
        // R4 R5: all control characters, twice for both polarities
        for (int r = 0; r < 2; r++)
            for (int i = 0; i < 12; i++) send(ks[i][7:0], 1'b1, "R4 R5 control");
        // R9: legitimate 0xFF data
        send(8'hFF, 1'b0, "R9 data FF");
        // R2: idle cycle
        drive(1'b0, 1'b1, 10'h155, 8'h00, 1'b0, 1'b0, "R2 idle");
        // R7: K28.5 in the wrong disparity form
        drive(1'b1, 1'b1, benc(8'hBC, 1'b1, ~brd), 8'hFF, 1'b0, 1'b1, "R7 disparity");
        send(8'hBC, 1'b1, "R8 after disparity error");
        // R6 R8: all-zero group, then negative disparity
        drive(1'b1, 1'b1, 10'b0000000000, 8'hFF, 1'b0, 1'b1, "R6 invalid zeros");
        send(8'h1C, 1'b1, "R8 neg after zeros");
        drive(1'b1, 1'b1, 10'b1111111111, 8'hFF, 1'b0, 1'b1, "R6 invalid ones");
        send(8'h1C, 1'b1, "R8 pos after ones");
        send(8'h4A, 1'b0, "R8 data after ones");
        // R11: K28 prefix with no valid tail
        drive(1'b1, 1'b1, brd ? 10'b1100001111 : 10'b0011110000, 8'hFF, 1'b0, 1'b1,
              "R11 bad K28 tail");
        send(8'hFC, 1'b1, "R8 after R11");
        // R10: bypass leaves flags low and disparity untouched
        drive(1'b1, 1'b0, 10'b0000000000, 8'h00, 1'b0, 1'b0, "R10 bypass zeros");
        drive(1'b1, 1'b0, 10'b1111111111, 8'h00, 1'b0, 1'b0, "R10 bypass ones");
        drive(1'b1, 1'b0, benc(8'hBC, 1'b1, brd), 8'h00, 1'b0, 1'b0, "R10 bypass comma");
        send(8'hBC, 1'b1, "R10 disparity held");
        send(8'h00, 1'b0, "R10 data after bypass");
        drive(1'b0, 1'b1, 10'h000, 8'h00, 1'b0, 1'b0, "R2 tail idle");
        repeat (3) @(negedge clk);
        report();
    end
endmodule